// File: doc/BRIEF.md
# Partial System Address Decoder with Boot-Vector Remap

This block turns each bus address from a single master into a one-hot slave select. The targets are ROM, RAM, one-time-programmable memory, five peripheral groups, the processor's private peripheral region and a default error slave. Each region is matched on only as many upper address bits as it needs. The memory map therefore contains aliases on purpose, and software may use them. The RAM is one example: it appears across a 256 kB span, which gives firmware an unbroken RAM view from 2005_C000h to 2006_3FFFh. The OTP array is another: it answers at two adjacent 64 kB windows.

A one-bit configuration register holds the remap control. While it is clear, the bottom of the map belongs to ROM, so boot uses the exception vectors that ROM holds. Once software has placed its own vectors in RAM, it sets the bit. From then on the lowest 1 kB window, which covers the vector table, goes to RAM. The selects are combinational for the address phase.

A registered copy of the selects serves the data phase. It loads only in cycles where `bus_ready` is high and holds otherwise. This is the only back-pressure rule: a stalled bus freezes the data-phase select, and the address-phase decode keeps following its inputs.

Top module: `sys_addr_decode`

## Requirements
- R1: With remap clear, every address from 0000_0000h to 0001_FFFFh selects ROM (sel bit 0), including address 0.
- R2: With remap set, addresses 0000_0000h to 0000_03FFh select RAM (sel bit 1). Addresses 0000_0400h to 0001_FFFFh still select ROM.
- R3: Addresses 2004_0000h to 2007_FFFFh select RAM, so the span 2005_C000h to 2006_3FFFh is contiguous RAM.
- R4: Addresses 3002_0000h to 3003_FFFFh select OTP (sel bit 2). The upper 64 kB is an alias of the lower.
- R5: The ranges 4000_0000h–400F_FFFFh, 5000_0000h–500F_FFFFh and 6000_0000h–600F_FFFFh select peripheral groups 3, 4 and 5 (sel bits 3, 4, 5).
- R6: 7000_0000h–7007_FFFFh selects group 6 (sel bit 6), and 7008_0000h–700F_FFFFh selects group 7 (sel bit 7).
- R7: E000_0000h–E00F_FFFFh selects the private peripheral region (sel bit 8).
- R8: Any valid address outside all the ranges above selects the error slave (sel bit 9) alone.
- R9: When `addr_valid` is high, `sel` has exactly one bit set. When it is low, `sel` is all zero.
- R10: The remap bit resets to 0. A clock edge with `cfg_wr_en` high loads `cfg_wr_data`, and `remap_q` shows the stored value. Decode uses the new value from the cycle after the write.
- R11: `sel_dphase` resets to zero. It loads `sel` on a clock edge where `bus_ready` is high and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 32 | Address-phase address |
| addr_valid | input | 1 | Transfer valid strobe |
| bus_ready | input | 1 | Bus ready; advances the data-phase select |
| cfg_wr_en | input | 1 | Write enable for the remap bit |
| cfg_wr_data | input | 1 | Value written to the remap bit |
| remap_q | output | 1 | Current remap bit |
| sel | output | 10 | Address-phase one-hot select |
| sel_dphase | output | 10 | Registered data-phase select |

## Verification
A write to the remap bit can land in the same cycle as an access to the vector window. The access must decode with the old remap value, and the new value must take effect only on the next access. The bench sets up this case by driving a remap write together with an access to address 0, for both a set and a clear of the bit. It then compares both cycles against its own reference decode. A stall can also coincide with a change of region, so the bench also holds `bus_ready` low during some remap flips and region changes to confirm that the data-phase select keeps the earlier target.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  localparam int NSEL     = 10;
  localparam int NREGION  = 9;
  localparam int S_ROM    = 0;
  localparam int S_RAM    = 1;
  localparam int S_OTP    = 2;
  localparam int S_PG3    = 3;
  localparam int S_PG4    = 4;
  localparam int S_PG5    = 5;
  localparam int S_PG6    = 6;
  localparam int S_PG7    = 7;
  localparam int S_PPB    = 8;
  localparam int S_ERR    = 9;

  // Region tag: address bits [31:lsb] must equal base[31:lsb]
  localparam logic [31:0] REGION_BASE [NREGION] = '{
    32'h0000_0000, 32'h2004_0000, 32'h3002_0000,
    32'h4000_0000, 32'h5000_0000, 32'h6000_0000,
    32'h7000_0000, 32'h7008_0000, 32'hE000_0000
  };
  localparam int REGION_LSB [NREGION] = '{
    17, 18, 17, 20, 20, 20, 19, 19, 20
  };
endpackage

// File: rtl/region_tag_cmp.sv
module region_tag_cmp #(
  parameter int          LSB  = 20,
  parameter logic [31:0] BASE = 32'h0
) (
  input  logic [31-LSB:0] tag,
  output logic            hit
);
  localparam logic [31-LSB:0] KEY = BASE[31:LSB];
  assign hit = (tag == KEY);
endmodule

// File: rtl/addr_decode_core.sv
module addr_decode_core
  import addr_map_pkg::*;
#(
  parameter int REMAP_LSB = 10
) (
  input  logic [31:REMAP_LSB] addr_hi,
  input  logic                valid,
  input  logic                remap,
  output logic [NSEL-1:0]     sel
);
  logic [NREGION-1:0] hit;
  logic               in_window;
  logic [NSEL-1:0]    raw;

  for (genvar g = 0; g < NREGION; g++) begin : g_region
    region_tag_cmp #(
      .LSB  (REGION_LSB[g]),
      .BASE (REGION_BASE[g])
    ) u_cmp (
      .tag (addr_hi[31:REGION_LSB[g]]),
      .hit (hit[g])
    );
  end

  assign in_window = (addr_hi == '0);

  always_comb begin
    raw = '0;
    raw[NREGION-1:0] = hit;
    if (remap && in_window) begin
      raw[S_ROM] = 1'b0;
      raw[S_RAM] = 1'b1;
    end
    raw[S_ERR] = ~|hit;
    sel = valid ? raw : '0;
  end
endmodule

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic remap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remap <= 1'b0;
    else if (wr_en) remap <= wr_data;
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (remap == $past(wr_data))); // R10
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(remap)); // R10
endmodule

// File: rtl/dphase_sel_reg.sv
module dphase_sel_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ready,
  input  logic [W-1:0] sel_in,
  output logic [W-1:0] sel_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_out <= '0;
    else if (ready) sel_out <= sel_in;
  end

  AST_DPH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (sel_out == $past(sel_in))); // R11
  AST_DPH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(sel_out)); // R11
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
  import addr_map_pkg::*;
#(
  parameter int REMAP_LSB = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     addr,
  input  logic            addr_valid,
  input  logic            bus_ready,
  input  logic            cfg_wr_en,
  input  logic            cfg_wr_data,
  output logic            remap_q,
  output logic [NSEL-1:0] sel,
  output logic [NSEL-1:0] sel_dphase
);
  logic addr_lo_unused;
  assign addr_lo_unused = ^addr[REMAP_LSB-1:0];

  remap_cfg_reg u_remap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .remap   (remap_q)
  );

  addr_decode_core #(.REMAP_LSB(REMAP_LSB)) u_core (
    .addr_hi (addr[31:REMAP_LSB]),
    .valid   (addr_valid),
    .remap   (remap_q),
    .sel     (sel)
  );

  dphase_sel_reg #(.W(NSEL)) u_dph (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (bus_ready),
    .sel_in  (sel),
    .sel_out (sel_dphase)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $countones(sel) == 1); // R9
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> sel == '0); // R9
  AST_BOOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !remap_q && addr == 32'h0) |-> sel[S_ROM]); // R1
  AST_BOOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && remap_q && addr == 32'h0) |-> sel[S_RAM]); // R2
endmodule

// File: tb/sys_addr_decode_bench.sv
module sys_addr_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        addr_valid = 1'b0;
  logic        bus_ready = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_data = 1'b0;
  logic        remap_q;
  logic [9:0]  sel;
  logic [9:0]  sel_dphase;

  int total = 0;
  int fails = 0;
  logic       m_remap = 1'b0;
  logic [9:0] m_dph = '0;

  always #5 clk = ~clk;

  sys_addr_decode u_sys_addr_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
    .bus_ready(bus_ready), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .remap_q(remap_q), .sel(sel), .sel_dphase(sel_dphase)
  );

  function automatic logic [9:0] ref_dec(input logic [31:0] a, input logic rm);
    logic [9:0] r = '0;
    if (rm && a <= 32'h0000_03FF)                      r[1] = 1'b1;
    else if (a <= 32'h0001_FFFF)                       r[0] = 1'b1;
    else if (a >= 32'h2004_0000 && a <= 32'h2007_FFFF) r[1] = 1'b1;
    else if (a >= 32'h3002_0000 && a <= 32'h3003_FFFF) r[2] = 1'b1;
    else if (a >= 32'h4000_0000 && a <= 32'h400F_FFFF) r[3] = 1'b1;
    else if (a >= 32'h5000_0000 && a <= 32'h500F_FFFF) r[4] = 1'b1;
    else if (a >= 32'h6000_0000 && a <= 32'h600F_FFFF) r[5] = 1'b1;
    else if (a >= 32'h7000_0000 && a <= 32'h7007_FFFF) r[6] = 1'b1;
    else if (a >= 32'h7008_0000 && a <= 32'h700F_FFFF) r[7] = 1'b1;
    else if (a >= 32'hE000_0000 && a <= 32'hE00F_FFFF) r[8] = 1'b1;
    else                                               r[9] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic v, input logic [9:0] e);
    if (!v) return "R9";
    if (a <= 32'h0001_FFFF) return m_remap ? "R2" : "R1";
    if (e[1]) return "R3";
    if (e[2]) return "R4";
    if (e[3] || e[4] || e[5]) return "R5";
    if (e[6] || e[7]) return "R6";
    if (e[8]) return "R7";
    return "R8";
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic v, input logic rdy,
                        input logic we, input logic wd);
    logic [9:0] exp;
    @(negedge clk);
    addr = a; addr_valid = v; bus_ready = rdy; cfg_wr_en = we; cfg_wr_data = wd;
    #1;
    exp = v ? ref_dec(a, m_remap) : 10'h0;
    check(sel === exp, tag_of(a, v, exp), "sel", {22'h0, sel}, {22'h0, exp});
    @(posedge clk);
    #1;
    if (rdy) m_dph = exp;
    if (we)  m_remap = wd;
    check(sel_dphase === m_dph, "R11", "sel_dphase", {22'h0, sel_dphase}, {22'h0, m_dph});
    check(remap_q === m_remap, "R10", "remap_q", {31'h0, remap_q}, {31'h0, m_remap});
  endtask

  localparam logic [31:0] LO [11] = '{
    32'h0000_0000, 32'h0000_0000, 32'h2004_0000, 32'h2005_C000, 32'h3002_0000,
    32'h4000_0000, 32'h5000_0000, 32'h6000_0000, 32'h7000_0000, 32'h7008_0000,
    32'hE000_0000 };
  localparam logic [31:0] HI [11] = '{
    32'h0000_03FF, 32'h0001_FFFF, 32'h2007_FFFF, 32'h2006_3FFF, 32'h3003_FFFF,
    32'h400F_FFFF, 32'h500F_FFFF, 32'h600F_FFFF, 32'h7007_FFFF, 32'h700F_FFFF,
    32'hE00F_FFFF };

  initial begin : watchdog
    #2000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    void'($urandom(32'd1234));
    // reset state, with a write attempt held in reset
    cfg_wr_en = 1'b1; cfg_wr_data = 1'b1; bus_ready = 1'b1; addr_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(remap_q === 1'b0, "R10", "reset remap_q", {31'h0, remap_q}, 32'h0);
    check(sel_dphase === 10'h0, "R11", "reset sel_dphase", {22'h0, sel_dphase}, 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0; addr_valid = 1'b0; rst_n = 1'b1;

    // boundary sweep, remap clear then set
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) access(32'h0, 1'b0, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 11; i++) begin
        access(LO[i] - 32'h1, 1'b1, 1'b1, 1'b0, 1'b0);
        access(LO[i],         1'b1, 1'b1, 1'b0, 1'b0);
        access(HI[i],         1'b1, 1'b1, 1'b0, 1'b0);
        access(HI[i] + 32'h1, 1'b1, 1'b1, 1'b0, 1'b0);
      end
    end
    access(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0); // R8
    access(32'h3002_0000, 1'b0, 1'b1, 1'b0, 1'b0); // R9 idle

    // same-cycle remap write and vector fetch: R10
    access(32'h0, 1'b1, 1'b1, 1'b1, 1'b0); // still RAM, clears
    access(32'h0, 1'b1, 1'b1, 1'b1, 1'b1); // ROM this cycle, sets
    access(32'h0, 1'b1, 1'b1, 1'b0, 1'b0); // RAM now
    // stall across a remap flip and region change: R11
    access(32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    access(32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    access(32'h0, 1'b1, 1'b1, 1'b0, 1'b0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3) == 0) a = $urandom();
      else a = LO[$urandom_range(10)] + ($urandom() & ((32'h1 << $urandom_range(21)) - 1));
      access(a, ($urandom_range(7) != 0), ($urandom_range(3) != 0),
             ($urandom_range(15) == 0), $urandom_range(1) == 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule